// File: doc/BRIEF.md
# Serial Register-to-Register Copy Controller

This block holds two N-bit shift registers, a source and a destination, and copies the source into the destination over one serial bit path. Software or a neighbouring block loads either register in parallel while the block is idle. It then raises a start request, and the block opens a shift window that lasts exactly N clock cycles. Any shorter or longer window would leave the destination wrong.

During the window, both registers shift right once per cycle. The source feeds its outgoing least significant bit back into its own most significant position, so it rotates and ends up holding its starting value. The same bit enters the destination at its most significant position. The destination's outgoing least significant bit is presented on a registered serial output. The window is a synchronous shift enable driven by a down-counter, and the clock is never gated. A one-cycle done pulse marks the end of the window.

Top module: `sreg_xfer`

## Requirements
- R1: While reset is asserted (rst_n low), both registers, the serial output, busy and done are all 0.
- R2: While busy is low, a high ld_src (ld_dst) at a clock edge loads src_in (dst_in) into the source (destination). The new value is visible after that edge.
- R3: While busy is high, ld_src and ld_dst have no effect on either register.
- R4: A start at an edge where busy is low makes busy high for exactly N consecutive cycles, beginning after that edge.
- R5: A start while busy is high is ignored. The window neither lengthens nor restarts.
- R6: done is high for exactly one cycle: the cycle right after the Nth shift edge, which is also the first cycle with busy low again.
- R7: At each edge with busy high, the source rotates right. The new bit N-1 is the old bit 0. After N shifts the source equals its starting value.
- R8: At each edge with busy high, the destination shifts right and takes the source's old bit 0 into bit N-1. After a full window the destination equals the source value from before the window.
- R9: ser_out takes the destination's old bit 0 at each edge with busy high, and holds its value at all other edges. For source 1101 and destination 1001 with N=4, the values are 1, 0, 0, 1. After each of those shifts the source reads 1110, 0111, 1011, 1101 and the destination reads 1100, 0110, 1011, 1101.
- R10: When a load and start arrive at the same idle edge, the load takes effect, and the window that follows shifts the newly loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_src | input | 1 | Parallel load request for the source register |
| ld_dst | input | 1 | Parallel load request for the destination register |
| src_in | input | N | Parallel value for the source register |
| dst_in | input | N | Parallel value for the destination register |
| start | input | 1 | Request to open an N-cycle transfer window |
| busy | output | 1 | High during the N shift cycles |
| done | output | 1 | One-cycle pulse after the last shift |
| ser_out | output | 1 | Last bit shifted out of the destination |
| src_q | output | N | Current source register value |
| dst_q | output | N | Current destination register value |

## Verification
A parallel load and a start can land on the same idle edge. The bench drives that in about half of the random transfers and in a directed case. It judges the result by requiring that the following window shift the newly loaded values, so that the destination ends equal to the freshly loaded source. The other collision is a start or load arriving mid-window. The bench injects random start and load pulses during busy, checks that busy still lasts exactly N cycles, and checks that neither register departs from the shift model.

// File: rtl/sreg_xfer.sv
module sreg_xfer #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_src,
  input  logic         ld_dst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] dst_in,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         ser_out,
  output logic [N-1:0] src_q,
  output logic [N-1:0] dst_q
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign busy = (cnt != '0);
  assign last = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      ser_out <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else if (busy) begin
      src_q   <= {src_q[0], src_q[N-1:1]};
      dst_q   <= {src_q[0], dst_q[N-1:1]};
      ser_out <= dst_q[0];
      cnt     <= cnt - CW'(1);
      done    <= last;
    end else begin
      done <= 1'b0;
      if (ld_src) src_q <= src_in;
      if (ld_dst) dst_q <= dst_in;
      if (start)  cnt   <= CW'(N);
    end
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N));

  p_busy_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt == $past(cnt) - CW'(1)));

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_src_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (src_q[N-1] == $past(src_q[0])));

  p_dst_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dst_q[N-1] == $past(src_q[0])));

  p_ser_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ser_out));

  p_load_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_dst) |=> (dst_q[N-2:0] == $past(dst_q[N-1:1])));
endmodule

// File: tb/sreg_xfer_tb.sv
module sreg_xfer_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_src = 1'b0, ld_dst = 1'b0, start = 1'b0;
  logic [N-1:0] src_in = '0, dst_in = '0;
  logic         busy, done, ser_out;
  logic [N-1:0] src_q, dst_q;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [N-1:0] m_src = '0, m_dst = '0;
  logic         m_ser = 1'b0, m_done = 1'b0;
  int           m_cnt = 0;

  always #10 clk = ~clk;

  sreg_xfer #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_src(ld_src), .ld_dst(ld_dst),
    .src_in(src_in), .dst_in(dst_in), .start(start),
    .busy(busy), .done(done), .ser_out(ser_out),
    .src_q(src_q), .dst_q(dst_q)
  );

  function automatic logic [N-1:0] rot_r(logic [N-1:0] v);
    return {v[0], v[N-1:1]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(src_q == m_src, "R7", "src_q", int'(src_q), int'(m_src));
    check(dst_q == m_dst, "R8", "dst_q", int'(dst_q), int'(m_dst));
    check(ser_out == m_ser, "R9", "ser_out", int'(ser_out), int'(m_ser));
    check(busy == (m_cnt != 0), "R4", "busy", int'(busy), int'(m_cnt != 0));
    check(done == m_done, "R6", "done", int'(done), int'(m_done));
  endtask

  task automatic step();
    if (m_cnt != 0) begin
      m_done = (m_cnt == 1);
      m_ser  = m_dst[0];
      m_dst  = {m_src[0], m_dst[N-1:1]};
      m_src  = rot_r(m_src);
      m_cnt--;
    end else begin
      m_done = 1'b0;
      if (ld_src) m_src = src_in;
      if (ld_dst) m_dst = dst_in;
      if (start)  m_cnt = N;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    ld_src = 0; ld_dst = 0; start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    src_in = 4'hF; dst_in = 4'hF; ld_src = 1; ld_dst = 1; start = 1;
    repeat (3) @(negedge clk);
    check(src_q == 0 && dst_q == 0, "R1", "regs in reset", int'({src_q, dst_q}), 0);
    check(!busy && !done && !ser_out, "R1", "flags in reset", int'({busy, done, ser_out}), 0);
    idle_inputs();
    rst_n = 1;
    @(negedge clk);

    // R2: directed idle load
    src_in = 4'b1101; dst_in = 4'b1001; ld_src = 1; ld_dst = 1;
    step();
    idle_inputs();
    check(src_q == 4'b1101 && dst_q == 4'b1001, "R2", "parallel load",
          int'({src_q, dst_q}), int'({4'b1101, 4'b1001}));

    // R9: worked example
    start = 1;
    step();
    idle_inputs();
    begin
      logic [N-1:0] es [4] = '{4'b1110, 4'b0111, 4'b1011, 4'b1101};
      logic [N-1:0] ed [4] = '{4'b1100, 4'b0110, 4'b1011, 4'b1101};
      logic         eo [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
      for (int k = 0; k < 4; k++) begin
        step();
        check(src_q == es[k], "R9", "example src", int'(src_q), int'(es[k]));
        check(dst_q == ed[k], "R9", "example dst", int'(dst_q), int'(ed[k]));
        check(ser_out == eo[k], "R9", "example ser", int'(ser_out), int'(eo[k]));
      end
    end
    check(done && !busy, "R6", "done at end", int'({done, busy}), 2);
    step();
    check(!done, "R6", "done one cycle", int'(done), 0);
    repeat (3) step();
    check(ser_out == 1'b1, "R9", "ser hold idle", int'(ser_out), 1);

    // R10: directed load+start same edge
    src_in = 4'b0110; dst_in = 4'b1111; ld_src = 1; ld_dst = 1; start = 1;
    step();
    idle_inputs();
    check(busy && src_q == 4'b0110, "R10", "load with start",
          int'({busy, src_q}), int'({1'b1, 4'b0110}));
    repeat (N) step();
    check(dst_q == 4'b0110, "R10", "dst after load+start", int'(dst_q), 4'b0110);

    // random transfers with mid-window junk
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] a;
      int nbusy;
      a = N'($urandom);
      src_in = a; dst_in = N'($urandom);
      if ($urandom % 2) begin
        ld_src = 1; ld_dst = 1;
        step();
        idle_inputs();
        start = 1;
      end else begin
        ld_src = 1; ld_dst = 1; start = 1;
      end
      step();
      nbusy = busy ? 1 : 0;
      for (int k = 0; k < N; k++) begin
        start  = ($urandom % 3) == 0;
        ld_src = ($urandom % 3) == 0;
        ld_dst = ($urandom % 3) == 0;
        src_in = N'($urandom); dst_in = N'($urandom);
        if (k == N - 1) idle_inputs();
        step();
        if (busy) nbusy++;
      end
      check(nbusy == N, "R5", "window length with stray start", nbusy, N);
      check(src_q == a, "R7", "source restored", int'(src_q), int'(a));
      check(dst_q == a, "R8", "destination copy", int'(dst_q), int'(a));
      check(done, "R6", "done after window", int'(done), 1);
      step();
    end

    // R3: load while busy, observed through ports
    src_in = 4'b1000; ld_src = 1; start = 1;
    step();
    idle_inputs();
    src_in = 4'b0011; dst_in = 4'b0101; ld_src = 1; ld_dst = 1;
    step();
    idle_inputs();
    check(src_q == 4'b0100, "R3", "load ignored while busy", int'(src_q), 4'b0100);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule